// File: doc/BRIEF.md
# Radio Link Transmit/Receive Sequencer

This block drives a 2.4 GHz packet radio through a lower SPI transaction engine. It takes on one of two roles, fixed by a parameter. In the transmit role it programs the radio's own address once after reset. It then sends one-byte payloads. Before each payload it rewrites the radio setup and loads the byte. It pulses chip-enable to launch the packet, then polls the status register and reports either delivery or failure. In the receive role it programs the radio for listening and raises chip-enable. After that it polls without end. Each time a byte arrives it clears the flags, reads the payload and presents it with a one-cycle strobe.

Every radio access is one engine transaction. The sequencer places up to six bytes on `eng_data` and holds `eng_req` high. Byte 0 sits in bits 7:0 and is sent first; it is the command byte. The sequencer then waits for `eng_done`. With `eng_done` the engine returns the byte it received during the last byte of the transaction. The register program is a fixed table, and the sequencer walks it with a step counter. The 5-byte pipe address and the role are parameters. The chip-enable pulse width is given in microseconds and converted to system clocks.

Top module: `radio_link_seq`

## Requirements
- R1: During and after reset, `ce`, `eng_req`, `tx_done`, `tx_ready` and `rx_valid` are low.
- R2: Once `eng_req` rises, it stays high until the cycle after `eng_done`, and `eng_data` stays stable over that whole span. `eng_len` gives the byte count, including the command byte in bits 7:0. A status poll is the two bytes 0x07, 0xFF, and the status byte comes back on `eng_rdata` with `eng_done`.
- R3: In the transmit role, the sequencer first issues two 6-byte writes of `ADDR`, least significant byte first: command 0x30, then command 0x2A. Only after both does it raise `tx_ready`.
- R4: For each transmit byte, the sequencer issues these 2-byte transactions in order (command first): 27 70, E1 FF, 20 00, 21 01, 22 01, 23 03, 24 1A, 25 6E, 26 06, 20 0E, A0 payload.
- R5: In the transmit role, `ce` is low during every transaction. After the payload is loaded, `ce` is high for exactly CLK_HZ/1e6 × CE_PULSE_US clocks.
- R6: After the pulse, the sequencer polls status. If bit 4 is set, the result is failure (`tx_ok`=0). This holds even when bit 5 is also set. If only bit 5 is set, the result is success (`tx_ok`=1). With neither bit set, it polls again.
- R7: If POLL_LIMIT polls in a row show neither bit 4 nor bit 5, the byte is reported as failed, and no further poll is made.
- R8: A byte is taken on a clock where `tx_valid` and `tx_ready` are both high. `tx_ready` is low from the next cycle until the result. The result is a one-cycle `tx_done` pulse, with `tx_ok` valid in that cycle.
- R9: In the receive role, with `ce` low, the sequencer issues: E2 FF, 20 0F, 21 01, 23 03, 25 6E, 26 06, 22 01, a 6-byte write 2A followed by `ADDR` least significant byte first, and 31 01. Then it drives `ce` high.
- R10: In the receive role, the sequencer polls status until bit 6 is set. It then issues 27 70 and then 61 FF. The byte returned by the read appears on `rx_byte` with a one-cycle `rx_valid`, and polling resumes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_valid | input | 1 | Payload byte offered |
| tx_byte | input | 8 | Payload byte to send |
| tx_ready | output | 1 | Sequencer waiting for a payload byte |
| tx_done | output | 1 | One-cycle result strobe |
| tx_ok | output | 1 | Result: 1 delivered, 0 failed |
| rx_valid | output | 1 | One-cycle strobe for a received byte |
| rx_byte | output | 8 | Received payload byte |
| ce | output | 1 | Radio chip-enable |
| eng_req | output | 1 | Transaction request to the SPI engine |
| eng_len | output | 3 | Bytes in the transaction |
| eng_data | output | 48 | Transaction bytes, byte 0 in bits 7:0 |
| eng_done | input | 1 | Engine finished the transaction |
| eng_rdata | input | 8 | Byte received during the last byte |

## Verification
The transmit outcome decode sees both interrupt flags in the same status byte. The bench's radio model can be armed with a status that has both delivery and max-retry set. In that case the reported result must be failure. The bench also places a success on the very last poll allowed, so that the flag decode and the timeout fall in the same poll. That byte must still be reported as delivered, after exactly POLL_LIMIT polls.

// File: rtl/rls_pkg.sv
package rls_pkg;

   localparam int ADDR_BYTES = 5;
   localparam int XFER_BYTES = ADDR_BYTES + 1;
   localparam int PCW        = 5;

   typedef enum logic [3:0] {
      K_XFER, K_LOAD, K_CE_LO, K_CE_HI, K_CE_PULSE,
      K_WAIT_TX, K_POLL_TX, K_POLL_RX, K_READ
   } kind_e;

   typedef enum logic [1:0] {S_ISSUE, S_WAIT, S_PULSE} state_e;

   typedef struct packed {
      kind_e                   kind;
      logic [2:0]              len;
      logic [PCW-1:0]          tgt;
      logic [8*XFER_BYTES-1:0] bytes;
   } step_t;

   function automatic step_t mk(kind_e k, logic [2:0] n, logic [7:0] b0,
                                logic [7:0] b1, logic [PCW-1:0] t);
      step_t s;
      s.kind  = k;
      s.len   = n;
      s.tgt   = t;
      s.bytes = '0;
      s.bytes[7:0]  = b0;
      s.bytes[15:8] = b1;
      return s;
   endfunction

   function automatic step_t wr_addr(logic [7:0] cmd, logic [8*ADDR_BYTES-1:0] a);
      step_t s;
      s = mk(K_XFER, 3'(XFER_BYTES), cmd, 8'h00, '0);
      s.bytes[8*XFER_BYTES-1:8] = a;
      return s;
   endfunction

   // transmit role program; step 2 is the idle point between bytes
   function automatic step_t tx_prog(logic [PCW-1:0] pc, logic [8*ADDR_BYTES-1:0] a);
      case (pc)
         5'd0:    return wr_addr(8'h30, a);
         5'd1:    return wr_addr(8'h2A, a);
         5'd3:    return mk(K_XFER, 3'd2, 8'h27, 8'h70, '0);
         5'd4:    return mk(K_CE_LO, 3'd0, 8'h00, 8'h00, '0);
         5'd5:    return mk(K_XFER, 3'd2, 8'hE1, 8'hFF, '0);
         5'd6:    return mk(K_XFER, 3'd2, 8'h20, 8'h00, '0);
         5'd7:    return mk(K_XFER, 3'd2, 8'h21, 8'h01, '0);
         5'd8:    return mk(K_XFER, 3'd2, 8'h22, 8'h01, '0);
         5'd9:    return mk(K_XFER, 3'd2, 8'h23, 8'h03, '0);
         5'd10:   return mk(K_XFER, 3'd2, 8'h24, 8'h1A, '0);
         5'd11:   return mk(K_XFER, 3'd2, 8'h25, 8'h6E, '0);
         5'd12:   return mk(K_XFER, 3'd2, 8'h26, 8'h06, '0);
         5'd13:   return mk(K_XFER, 3'd2, 8'h20, 8'h0E, '0);
         5'd14:   return mk(K_LOAD, 3'd2, 8'hA0, 8'h00, '0);
         5'd15:   return mk(K_CE_PULSE, 3'd0, 8'h00, 8'h00, '0);
         5'd16:   return mk(K_POLL_TX, 3'd2, 8'h07, 8'hFF, 5'd2);
         default: return mk(K_WAIT_TX, 3'd0, 8'h00, 8'h00, '0);
      endcase
   endfunction

   // receive role program; steps 11..13 loop forever
   function automatic step_t rx_prog(logic [PCW-1:0] pc, logic [8*ADDR_BYTES-1:0] a);
      case (pc)
         5'd0:    return mk(K_CE_LO, 3'd0, 8'h00, 8'h00, '0);
         5'd1:    return mk(K_XFER, 3'd2, 8'hE2, 8'hFF, '0);
         5'd2:    return mk(K_XFER, 3'd2, 8'h20, 8'h0F, '0);
         5'd3:    return mk(K_XFER, 3'd2, 8'h21, 8'h01, '0);
         5'd4:    return mk(K_XFER, 3'd2, 8'h23, 8'h03, '0);
         5'd5:    return mk(K_XFER, 3'd2, 8'h25, 8'h6E, '0);
         5'd6:    return mk(K_XFER, 3'd2, 8'h26, 8'h06, '0);
         5'd7:    return mk(K_XFER, 3'd2, 8'h22, 8'h01, '0);
         5'd8:    return wr_addr(8'h2A, a);
         5'd9:    return mk(K_XFER, 3'd2, 8'h31, 8'h01, '0);
         5'd10:   return mk(K_CE_HI, 3'd0, 8'h00, 8'h00, '0);
         5'd12:   return mk(K_XFER, 3'd2, 8'h27, 8'h70, '0);
         5'd13:   return mk(K_READ, 3'd2, 8'h61, 8'hFF, 5'd11);
         default: return mk(K_POLL_RX, 3'd2, 8'h07, 8'hFF, '0);
      endcase
   endfunction

endpackage

// File: rtl/rls_step_rom.sv
module rls_step_rom #(
   parameter bit                                ROLE_TX = 1'b1,
   parameter logic [8*rls_pkg::ADDR_BYTES-1:0]  ADDR    = '0
) (
   input  logic [rls_pkg::PCW-1:0] pc,
   output rls_pkg::step_t          step
);
   generate
      if (ROLE_TX) begin : g_tx
         assign step = rls_pkg::tx_prog(pc, ADDR);
      end else begin : g_rx
         assign step = rls_pkg::rx_prog(pc, ADDR);
      end
   endgenerate
endmodule

// File: rtl/rls_pulse_timer.sv
module rls_pulse_timer #(
   parameter int CYCLES = 500
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   output logic expired
);
   localparam int CNT_W = $clog2(CYCLES + 1);

   logic [CNT_W-1:0] cnt;

   initial begin
      assert (CYCLES >= 1) else $error("pulse timer needs at least one cycle");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)           cnt <= '0;
      else if (load)        cnt <= CNT_W'(CYCLES - 1);
      else if (cnt != '0)   cnt <= cnt - 1'b1;
   end

   assign expired = (cnt == '0);

   p_load_counts_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (load && CYCLES > 1) |=> !expired);
endmodule

// File: rtl/radio_link_seq.sv
module radio_link_seq
   import rls_pkg::*;
#(
   parameter bit                          ROLE_TX     = 1'b1,
   parameter logic [8*ADDR_BYTES-1:0]     ADDR        = 40'hA5_3C_96_0F_E1,
   parameter int                          CLK_HZ      = 50_000_000,
   parameter int                          CE_PULSE_US = 10,
   parameter int                          POLL_LIMIT  = 64
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    tx_valid,
   input  logic [7:0]              tx_byte,
   output logic                    tx_ready,
   output logic                    tx_done,
   output logic                    tx_ok,
   output logic                    rx_valid,
   output logic [7:0]              rx_byte,
   output logic                    ce,
   output logic                    eng_req,
   output logic [2:0]              eng_len,
   output logic [8*XFER_BYTES-1:0] eng_data,
   input  logic                    eng_done,
   input  logic [7:0]              eng_rdata
);
   localparam int CE_CYC = (CLK_HZ / 1_000_000) * CE_PULSE_US;
   localparam int PLW    = $clog2(POLL_LIMIT + 1);
   localparam int CEW    = $clog2(CE_CYC + 2);

   initial begin
      assert (CE_PULSE_US >= 10) else $error("chip-enable pulse below 10 us");
      assert (CE_CYC >= 1)       else $error("clock too slow for pulse");
      assert (POLL_LIMIT >= 1)   else $error("poll limit must be positive");
   end

   state_e         st;
   logic [PCW-1:0] pc;
   step_t          step;
   logic           req_q, ce_q, done_q, ok_q, rxv_q;
   logic [7:0]     pay_q, rxb_q;
   logic [PLW-1:0] polls;
   logic           tmr_load, tmr_exp;

   rls_step_rom #(.ROLE_TX(ROLE_TX), .ADDR(ADDR)) u_rom (
      .pc   (pc),
      .step (step)
   );

   assign tmr_load = (st == S_ISSUE) && (step.kind == K_CE_PULSE);

   rls_pulse_timer #(.CYCLES(CE_CYC)) u_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (tmr_load),
      .expired (tmr_exp)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st     <= S_ISSUE;
         pc     <= '0;
         req_q  <= 1'b0;
         ce_q   <= 1'b0;
         done_q <= 1'b0;
         ok_q   <= 1'b0;
         rxv_q  <= 1'b0;
         rxb_q  <= '0;
         pay_q  <= '0;
         polls  <= '0;
      end else begin
         done_q <= 1'b0;
         rxv_q  <= 1'b0;
         case (st)
            S_ISSUE: begin
               case (step.kind)
                  K_CE_LO: begin ce_q <= 1'b0; pc <= pc + 1'b1; end
                  K_CE_HI: begin ce_q <= 1'b1; pc <= pc + 1'b1; end
                  K_CE_PULSE: begin ce_q <= 1'b1; st <= S_PULSE; end
                  K_WAIT_TX: begin
                     if (tx_valid) begin
                        pay_q <= tx_byte;
                        polls <= '0;
                        pc    <= pc + 1'b1;
                     end
                  end
                  default: begin req_q <= 1'b1; st <= S_WAIT; end
               endcase
            end
            S_WAIT: begin
               if (eng_done) begin
                  req_q <= 1'b0;
                  st    <= S_ISSUE;
                  case (step.kind)
                     K_POLL_TX: begin
                        if (eng_rdata[4] || eng_rdata[5] ||
                            polls == PLW'(POLL_LIMIT - 1)) begin
                           done_q <= 1'b1;
                           ok_q   <= !eng_rdata[4] && eng_rdata[5];
                           pc     <= step.tgt;
                        end else begin
                           polls <= polls + 1'b1;
                        end
                     end
                     K_POLL_RX: if (eng_rdata[6]) pc <= pc + 1'b1;
                     K_READ: begin
                        rxv_q <= 1'b1;
                        rxb_q <= eng_rdata;
                        pc    <= step.tgt;
                     end
                     default: pc <= pc + 1'b1;
                  endcase
               end
            end
            S_PULSE: begin
               if (tmr_exp) begin
                  ce_q <= 1'b0;
                  pc   <= pc + 1'b1;
                  st   <= S_ISSUE;
               end
            end
            default: st <= S_ISSUE;
         endcase
      end
   end

   assign tx_ready = (st == S_ISSUE) && (step.kind == K_WAIT_TX);
   assign tx_done  = done_q;
   assign tx_ok    = ok_q;
   assign rx_valid = rxv_q;
   assign rx_byte  = rxb_q;
   assign ce       = ce_q;
   assign eng_req  = req_q;
   assign eng_len  = step.len;
   assign eng_data = (step.kind == K_LOAD)
                   ? {step.bytes[8*XFER_BYTES-1:16], pay_q, step.bytes[7:0]}
                   : step.bytes;

   // cycles chip-enable has been high, for the pulse-width check
   logic [CEW-1:0] ce_run;
   always_ff @(posedge clk) begin
      if (!rst_n)     ce_run <= '0;
      else if (ce_q)  ce_run <= ce_run + 1'b1;
      else            ce_run <= '0;
   end

   p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_req && !eng_done) |=> (eng_req && $stable(eng_data)));

   p_ce_low_xfer_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ROLE_TX && eng_req) |-> !ce);

   p_ce_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ROLE_TX && $fell(ce)) |-> (ce_run == CEW'(CE_CYC)));

   p_ready_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      tx_ready |-> (!eng_req && !ce));

   p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      tx_done |=> !tx_done);

   p_rx_after_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> $past(eng_done));
endmodule

// File: tb/radio_link_seq_test.sv
module rls_radio_model #(
   parameter int DEPTH = 4096
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        ce,
   input  logic        req,
   input  logic [2:0]  len,
   input  logic [47:0] data,
   output logic        done,
   output logic [7:0]  rdata
);
   int          n = 0;
   int          polls_before = 0;
   int          viol = 0;
   int          last_w = 0;
   int          hi = 0;
   int          lat = 0;
   bit          pend = 0;
   logic [7:0]  final_status = 8'h0E;
   logic [7:0]  arm_status = 8'h0E;
   logic [7:0]  rx_data = 8'h00;
   logic [7:0]  r;
   logic [47:0] held;
   logic [2:0]  lg_len [DEPTH];
   logic [47:0] lg_data [DEPTH];
   logic        lg_ce [DEPTH];

   initial begin done = 1'b0; rdata = 8'h00; end

   always @(posedge clk) begin
      done <= 1'b0;
      if (ce) hi = hi + 1;
      else if (hi != 0) begin
         last_w = hi;
         hi = 0;
         final_status = arm_status;
      end
      if (!rst_n) pend = 0;
      else if (pend) begin
         if (!req || data !== held) viol = viol + 1;
         if (lat == 0) begin
            case (data[7:0])
               8'h07: begin
                  if (polls_before > 0) begin
                     polls_before = polls_before - 1;
                     r = 8'h0E;
                  end else r = final_status;
               end
               8'h61: r = rx_data;
               8'h27: begin r = 8'h0E; final_status = 8'h0E; end
               default: r = 8'h0E;
            endcase
            lg_len[n % DEPTH]  = len;
            lg_data[n % DEPTH] = data;
            lg_ce[n % DEPTH]   = ce;
            n = n + 1;
            done  <= 1'b1;
            rdata <= r;
            pend = 0;
         end else lat = lat - 1;
      end else if (req && !done) begin
         pend = 1;
         lat  = $urandom_range(2, 0);
         held = data;
      end
   end
endmodule

module radio_link_seq_test;
   localparam int PERIOD = 10;
   localparam int CE_CYC = 20;
   localparam int PL     = 8;
   localparam int DEPTH  = 4096;
   localparam logic [39:0] ADDR = 40'h5A_C3_19_E7_42;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(PERIOD/2) clk = ~clk;

   int checks = 0;
   int bad = 0;
   bit finished = 0;

   logic        t_valid = 1'b0;
   logic [7:0]  t_byte = 8'h00;
   logic        t_ready, t_done, t_ok, t_rxv, t_ce, t_req, t_edone;
   logic [7:0]  t_rxb, t_erd;
   logic [2:0]  t_len;
   logic [47:0] t_data;
   logic        r_ready, r_done, r_ok, r_rxv, r_ce, r_req, r_edone;
   logic [7:0]  r_rxb, r_erd;
   logic [2:0]  r_len;
   logic [47:0] r_data;

   radio_link_seq #(.ROLE_TX(1'b1), .ADDR(ADDR), .CLK_HZ(2_000_000),
                    .CE_PULSE_US(10), .POLL_LIMIT(PL)) uut (
      .clk(clk), .rst_n(rst_n), .tx_valid(t_valid), .tx_byte(t_byte),
      .tx_ready(t_ready), .tx_done(t_done), .tx_ok(t_ok),
      .rx_valid(t_rxv), .rx_byte(t_rxb), .ce(t_ce), .eng_req(t_req),
      .eng_len(t_len), .eng_data(t_data), .eng_done(t_edone), .eng_rdata(t_erd));

   radio_link_seq #(.ROLE_TX(1'b0), .ADDR(ADDR), .CLK_HZ(2_000_000),
                    .CE_PULSE_US(10), .POLL_LIMIT(PL)) uut_rx (
      .clk(clk), .rst_n(rst_n), .tx_valid(1'b0), .tx_byte(8'h00),
      .tx_ready(r_ready), .tx_done(r_done), .tx_ok(r_ok),
      .rx_valid(r_rxv), .rx_byte(r_rxb), .ce(r_ce), .eng_req(r_req),
      .eng_len(r_len), .eng_data(r_data), .eng_done(r_edone), .eng_rdata(r_erd));

   rls_radio_model #(.DEPTH(DEPTH)) m_tx (
      .clk(clk), .rst_n(rst_n), .ce(t_ce), .req(t_req), .len(t_len),
      .data(t_data), .done(t_edone), .rdata(t_erd));

   rls_radio_model #(.DEPTH(DEPTH)) m_rx (
      .clk(clk), .rst_n(rst_n), .ce(r_ce), .req(r_req), .len(r_len),
      .data(r_data), .done(r_edone), .rdata(r_erd));

   task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                      input logic [63:0] exp);
      checks++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [50:0] two(input logic [7:0] cmd, input logic [7:0] val);
      return {3'd2, 32'h0, val, cmd};
   endfunction

   function automatic logic [50:0] ex_tx(input int k, input logic [7:0] p);
      case (k)
         0: return two(8'h27, 8'h70);
         1: return two(8'hE1, 8'hFF);
         2: return two(8'h20, 8'h00);
         3: return two(8'h21, 8'h01);
         4: return two(8'h22, 8'h01);
         5: return two(8'h23, 8'h03);
         6: return two(8'h24, 8'h1A);
         7: return two(8'h25, 8'h6E);
         8: return two(8'h26, 8'h06);
         9: return two(8'h20, 8'h0E);
         default: return two(8'hA0, p);
      endcase
   endfunction

   function automatic logic [50:0] ex_rx(input int k);
      case (k)
         0: return two(8'hE2, 8'hFF);
         1: return two(8'h20, 8'h0F);
         2: return two(8'h21, 8'h01);
         3: return two(8'h23, 8'h03);
         4: return two(8'h25, 8'h6E);
         5: return two(8'h26, 8'h06);
         6: return two(8'h22, 8'h01);
         7: return {3'd6, ADDR, 8'h2A};
         default: return two(8'h31, 8'h01);
      endcase
   endfunction

   task automatic run_tx(input int pb, input logic [7:0] fs, input logic [7:0] pay);
      int base;
      int mism;
      int cehi;
      int polls;
      bit exp_ok;
      int exp_polls;
      m_tx.polls_before = pb;
      m_tx.arm_status   = fs;
      m_tx.last_w       = 0;
      while (!t_ready) @(negedge clk);
      base = m_tx.n;
      t_valid = 1'b1;
      t_byte  = pay;
      @(negedge clk);
      t_valid = 1'b0;
      chk(!t_ready, "R8 ready low while busy", 64'(t_ready), 64'd0);
      while (!t_done) @(negedge clk);
      exp_ok    = (pb < PL) && !fs[4] && fs[5];
      exp_polls = (pb < PL) ? pb + 1 : PL;
      chk(t_ok == exp_ok, "R6 R7 outcome", 64'(t_ok), 64'(exp_ok));
      mism = 0;
      cehi = 0;
      for (int k = 0; k < 11; k++) begin
         if ({m_tx.lg_len[(base+k)%DEPTH], m_tx.lg_data[(base+k)%DEPTH]} !== ex_tx(k, pay))
            mism++;
      end
      for (int k = base; k < m_tx.n; k++) begin
         if (m_tx.lg_ce[k%DEPTH]) cehi++;
         if (k >= base + 11 &&
             {m_tx.lg_len[k%DEPTH], m_tx.lg_data[k%DEPTH]} !== two(8'h07, 8'hFF))
            mism++;
      end
      chk(mism == 0, "R4 transmit sequence", 64'(mism), 64'd0);
      polls = m_tx.n - base - 11;
      chk(polls == exp_polls, "R7 poll count", 64'(polls), 64'(exp_polls));
      chk(cehi == 0, "R5 ce low in transactions", 64'(cehi), 64'd0);
      chk(m_tx.last_w == CE_CYC, "R5 ce pulse width", 64'(m_tx.last_w), 64'(CE_CYC));
      @(negedge clk);
      chk(!t_done, "R8 single done pulse", 64'(t_done), 64'd0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++;
         bad++;
         $display("FAIL watchdog R8 actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", checks, bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] fsel [3];
      int         seed;
      int         mism;
      int         cehi;
      int         i0;
      seed = $urandom(1234);
      fsel[0] = 8'h2E; fsel[1] = 8'h1E; fsel[2] = 8'h3E;
      repeat (3) @(negedge clk);
      chk(!t_ce && !t_req && !t_done && !t_ready, "R1 tx reset outputs",
          {t_ce, t_req, t_done, t_ready}, 64'd0);
      chk(!r_ce && !r_req && !r_rxv, "R1 rx reset outputs",
          {r_ce, r_req, r_rxv}, 64'd0);
      rst_n = 1'b1;

      // transmit role bring-up
      while (!t_ready) @(negedge clk);
      chk(m_tx.n == 2, "R3 init count", 64'(m_tx.n), 64'd2);
      chk({m_tx.lg_len[0], m_tx.lg_data[0]} === {3'd6, ADDR, 8'h30}, "R3 tx address write",
          64'(m_tx.lg_data[0]), 64'({ADDR, 8'h30}));
      chk({m_tx.lg_len[1], m_tx.lg_data[1]} === {3'd6, ADDR, 8'h2A}, "R3 pipe address write",
          64'(m_tx.lg_data[1]), 64'({ADDR, 8'h2A}));

      // directed outcomes
      run_tx(0, 8'h2E, 8'h3C);
      run_tx(3, 8'h1E, 8'hC5);
      run_tx(1, 8'h3E, 8'h00);
      run_tx(100, 8'h2E, 8'hFF);
      run_tx(PL - 1, 8'h2E, 8'h81);
      for (int i = 0; i < 6; i++)
         run_tx($urandom_range(5, 0), fsel[$urandom_range(2, 0)], 8'($urandom));

      // receive role
      while (!r_ce) @(negedge clk);
      mism = 0;
      cehi = 0;
      for (int k = 0; k < 9; k++) begin
         if ({m_rx.lg_len[k], m_rx.lg_data[k]} !== ex_rx(k)) mism++;
         if (m_rx.lg_ce[k]) cehi++;
      end
      chk(mism == 0, "R9 receive setup", 64'(mism), 64'd0);
      chk(cehi == 0, "R9 ce low during setup", 64'(cehi), 64'd0);
      for (int i = 0; i < 6; i++) begin
         logic [7:0] d;
         d = 8'($urandom);
         m_rx.rx_data      = d;
         m_rx.polls_before = $urandom_range(3, 0);
         m_rx.final_status = 8'h4E;
         while (!r_rxv) @(negedge clk);
         chk(r_rxb == d, "R10 received byte", 64'(r_rxb), 64'(d));
         i0 = m_rx.n;
         chk(m_rx.lg_data[(i0-1)%DEPTH] === 48'hFF61 && m_rx.lg_data[(i0-2)%DEPTH] === 48'h7027,
             "R10 clear then read", 64'(m_rx.lg_data[(i0-1)%DEPTH]), 64'h FF61);
         @(negedge clk);
         chk(!r_rxv, "R10 single strobe", 64'(r_rxv), 64'd0);
      end
      chk(m_tx.viol == 0 && m_rx.viol == 0, "R2 request held stable",
          64'(m_tx.viol + m_rx.viol), 64'd0);

      finished = 1;
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end
endmodule